// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block governs a synchronous memory's low-power sleep state. An asynchronous, active-high sleep request is first made safe by a two-flop synchronizer. The controller then counts out a fixed entry window before declaring sleep. While asleep it closes the input gate, so every command collapses to deselect. It also closes the output gate, which the surrounding data drivers use to float the bus.

When the request falls, the controller does not return straight to normal service. It passes through a timed recovery window. In that window read and deselect commands go through, while a write is turned into a deselect and reported with a one-cycle reject flag. If the request falls before the entry window has finished, the controller returns directly to normal operation and skips recovery. The controller's own state is kept through sleep, and an asynchronous reset returns it to the active state from any state.

Top module: `sleep_power_ctrl`

## Requirements
- R1: While reset is held low and afterwards until a request arrives, sleepActive is 0, inEnable is 1, outEnable is 1, cmdOut is 00 and cmdReject is 0.
- R2: The request passes through a two-flop synchronizer. The first rising edge that sees the synchronized request starts an entry window of ENTRY_CYCLES (default 2) cycles. If the request is sampled high at edge k and held, sleepActive rises after edge k+4.
- R3: While sleepActive is 1, inEnable and outEnable are both 0, so the data outputs are driven to high impedance.
- R4: Commands sampled while asleep are ignored. The following cycle shows cmdOut = 00 and cmdReject = 0.
- R5: Sleep lasts for as long as the request stays high, however long that is.
- R6: If the request is first sampled low at edge k during sleep, sleepActive falls after edge k+2. A recovery window of RECOVERY_CYCLES (default 4) cycles follows, and then the controller returns to the active state.
- R7: During recovery, read (01) and deselect (00) are forwarded. A write (10) is blocked: the next cycle shows cmdOut = 00 and cmdReject = 1. The flag lasts one cycle for each rejected write.
- R8: If the synchronized request drops during the entry window, the controller returns straight to the active state. Writes are then accepted at once, with no recovery window.
- R9: Outside sleep and recovery, cmdOut after a rising edge equals cmdIn sampled at that edge. The encodings are 00 deselect, 01 read and 10 write. Code 11 is forwarded as 00.
- R10: Pulling rstN low while asleep clears sleepActive at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Asynchronous active-high sleep request |
| cmdIn | input | 2 | Incoming command: 00 deselect, 01 read, 10 write |
| sleepActive | output | 1 | High while the device is asleep |
| inEnable | output | 1 | Input gate: low while asleep |
| outEnable | output | 1 | Output gate: low means the data outputs float |
| cmdOut | output | 2 | Registered, filtered command |
| cmdReject | output | 1 | One-cycle flag for a write blocked during recovery |

## Verification
The filtered command and the reject flag settle one edge after the command is sampled. The sleep indicator and the gates follow the request four edges after it is first sampled high, and two edges after it is first sampled low. Recovery then lasts four further edges. The bench drives inputs on the falling edge and checks each vector at the next falling edge, so every row's expected values already include the synchronizer and the entry and recovery counts. Directed tests count rejected writes across a whole recovery window, hold sleep for a long stretch, and pulse reset while asleep.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_RSVD  = 2'b11
  } cmd_e;

  typedef enum logic [1:0] {
    ST_ACTIVE,
    ST_ENTERING,
    ST_SLEEP,
    ST_RECOVERING
  } pwr_state_e;

  typedef struct packed {
    logic asleep;
    logic gateIn;
    logic gateOut;
    logic recovering;
  } spc_strobe_t;

endpackage

// File: rtl/spc_sync.sv
module spc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int ENTRY_CYCLES    = 2,
  parameter int RECOVERY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqSync,
  output spc_strobe_t strobe
);
  localparam int MAX_CNT = (ENTRY_CYCLES > RECOVERY_CYCLES) ? ENTRY_CYCLES : RECOVERY_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYCLES - 1);
  localparam logic [CNT_W-1:0] RECOV_LOAD = CNT_W'(RECOVERY_CYCLES - 1);

  pwr_state_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_ACTIVE: if (reqSync) begin
        stateNext = ST_ENTERING;
        cntNext   = ENTRY_LOAD;
      end
      ST_ENTERING: begin
        if (!reqSync)        stateNext = ST_ACTIVE;
        else if (cnt == '0)  stateNext = ST_SLEEP;
        else                 cntNext   = cnt - 1'b1;
      end
      ST_SLEEP: if (!reqSync) begin
        stateNext = ST_RECOVERING;
        cntNext   = RECOV_LOAD;
      end
      ST_RECOVERING: begin
        if (cnt == '0) stateNext = ST_ACTIVE;
        else           cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_ACTIVE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  always_comb begin
    strobe.asleep     = (state == ST_SLEEP);
    strobe.gateIn     = (state != ST_SLEEP);
    strobe.gateOut    = (state != ST_SLEEP);
    strobe.recovering = (state == ST_RECOVERING);
  end
endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  spc_strobe_t strobe,
  input  logic [1:0]  cmdIn,
  output logic        sleepActive,
  output logic        inEnable,
  output logic        outEnable,
  output logic [1:0]  cmdOut,
  output logic        cmdReject
);
  logic blocked;
  logic [1:0] cmdFilt;
  logic [1:0] cmdQ;
  logic rejectQ;

  always_comb begin
    blocked = strobe.recovering && (cmdIn == CMD_WRITE);
    if (!strobe.gateIn || blocked || cmdIn == CMD_RSVD) cmdFilt = CMD_DESEL;
    else                                                 cmdFilt = cmdIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ    <= CMD_DESEL;
      rejectQ <= 1'b0;
    end else begin
      cmdQ    <= cmdFilt;
      rejectQ <= blocked;
    end
  end

  assign sleepActive = strobe.asleep;
  assign inEnable    = strobe.gateIn;
  assign outEnable   = strobe.gateOut;
  assign cmdOut      = cmdQ;
  assign cmdReject   = rejectQ;
endmodule

// File: rtl/sleep_power_ctrl.sv
module sleep_power_ctrl
  import spc_pkg::*;
#(
  parameter int SYNC_STAGES     = 2,
  parameter int ENTRY_CYCLES    = 2,
  parameter int RECOVERY_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic [1:0] cmdIn,
  output logic       sleepActive,
  output logic       inEnable,
  output logic       outEnable,
  output logic [1:0] cmdOut,
  output logic       cmdReject
);
  logic        reqSync;
  spc_strobe_t strobe;

  spc_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .asyncIn(sleepReq), .syncOut(reqSync)
  );

  spc_ctrl #(.ENTRY_CYCLES(ENTRY_CYCLES), .RECOVERY_CYCLES(RECOVERY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .reqSync(reqSync), .strobe(strobe)
  );

  spc_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdIn(cmdIn),
    .sleepActive(sleepActive), .inEnable(inEnable), .outEnable(outEnable),
    .cmdOut(cmdOut), .cmdReject(cmdReject)
  );
endmodule

// File: rtl/spc_checker.sv
module spc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sleepReq,
  input logic [1:0] cmdIn,
  input logic       sleepActive,
  input logic       inEnable,
  input logic       outEnable,
  input logic [1:0] cmdOut,
  input logic       cmdReject
);
  // R3
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepActive |-> (!inEnable && !outEnable));

  // R4
  sleep_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inEnable |=> (cmdOut == 2'b00 && !cmdReject));

  // R7
  reject_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdReject |-> (cmdOut == 2'b00));

  // R2
  entry_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepActive) |-> ($past(sleepReq, 3) && $past(sleepReq, 4)));

  // R6
  exit_sync_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleepActive) |-> !$past(sleepReq, 3));
endmodule

bind sleep_power_ctrl spc_checker uChk (
  .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .cmdIn(cmdIn),
  .sleepActive(sleepActive), .inEnable(inEnable), .outEnable(outEnable),
  .cmdOut(cmdOut), .cmdReject(cmdReject)
);

// File: tb/tb_sleep_power_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_power_ctrl;
  localparam int RECOV = 4;
  localparam int NVEC  = 22;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReq = 1'b0;
  logic [1:0] cmdIn = 2'b00;
  logic sleepActive, inEnable, outEnable, cmdReject;
  logic [1:0] cmdOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sleep_power_ctrl #(.RECOVERY_CYCLES(RECOV)) dut (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .cmdIn(cmdIn),
    .sleepActive(sleepActive), .inEnable(inEnable), .outEnable(outEnable),
    .cmdOut(cmdOut), .cmdReject(cmdReject)
  );

  // {req, cmd[1:0], expSleep, expIn, expOut, expCmd[1:0], expRej}
  // rows 0-1 R9; rows 2-7 R2/R3; rows 8-9 R4; rows 10-15 R6/R7; rows 16-20 R8; row 21 R9
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0},
    {1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0},
    {1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 2'b01, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0},
    {1'b1, 2'b10, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0},
    {1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0},
    {1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0},
    {1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0},
    {1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0},
    {1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1},
    {1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0},
    {1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1},
    {1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1},
    {1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0},
    {1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0},
    {1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b0, 2'b01, 1'b0, 1'b1, 1'b1, 2'b01, 1'b0},
    {1'b0, 2'b10, 1'b0, 1'b1, 1'b1, 2'b10, 1'b0},
    {1'b0, 2'b11, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0}
  };

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int rejects;
    int waited;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 sleepActive", int'(sleepActive), 0);
    check("R1 inEnable", int'(inEnable), 1);
    check("R1 outEnable", int'(outEnable), 1);
    check("R1 cmdOut", int'(cmdOut), 0);
    check("R1 cmdReject", int'(cmdReject), 0);
    rstN = 1'b1;
    @(negedge clk);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      sleepReq = VEC[i][8];
      cmdIn    = VEC[i][7:6];
      @(negedge clk);
      check("R3 sleepActive", int'(sleepActive), int'(VEC[i][5]));
      check("R3 inEnable", int'(inEnable), int'(VEC[i][4]));
      check("R3 outEnable", int'(outEnable), int'(VEC[i][3]));
      check("R9 cmdOut", int'(cmdOut), int'(VEC[i][2:1]));
      check("R7 cmdReject", int'(cmdReject), int'(VEC[i][0]));
    end

    // R5: long sleep stays asleep
    sleepReq = 1'b1;
    cmdIn    = 2'b00;
    repeat (8) @(negedge clk);
    check("R2 asleep after entry", int'(sleepActive), 1);
    waited = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sleepActive) waited++;
    end
    check("R5 sleep held for 60 cycles", waited, 60);

    // R6/R7: writes across a whole recovery window
    sleepReq = 1'b0;
    cmdIn    = 2'b10;
    rejects  = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cmdReject) rejects++;
      if (cmdOut == 2'b10) break;
    end
    check("R6 recovery window length", rejects, RECOV);
    check("R7 write accepted after recovery", int'(cmdOut), 2);

    // R10: asynchronous reset while asleep
    sleepReq = 1'b1;
    cmdIn    = 2'b00;
    repeat (8) @(negedge clk);
    check("R10 asleep before reset", int'(sleepActive), 1);
    #1 rstN = 1'b0;
    #0.5;
    check("R10 sleepActive cleared", int'(sleepActive), 0);
    sleepReq = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cmdIn = 2'b10;
    @(negedge clk);
    check("R10 write accepted after reset", int'(cmdOut), 2);
    check("R10 no reject after reset", int'(cmdReject), 0);

    finishRun();
  end
endmodule